// File: doc/BRIEF.md
# Banked GPIO Pin Configuration Controller

This block stores the configuration of a row of pads and presents it to software as a small 32-bit register space. The pads are grouped into banks. Each bank is a run of consecutive pin numbers. For each kind of setting, a bank owns a contiguous run of bits that begins at an offset chosen per bank. Because of this, one register word can hold bits of several banks, and a bank can continue from one word into the next. The six kinds of setting are pad direction, output level, live input level, pull enable, pull polarity, and a 2-bit drive-strength code. Each kind has its own base word.

Software writes settings one byte lane at a time, or as whole words. It reads back the stored settings, and it reads the pad input levels after a two-flop synchronizer. Toward the pads, the block drives output-enable, output level, pull enable, pull-up select and the drive code for every pin. Pins that belong to no bank keep their reset values for good.

The bank table and the class layout are elaboration-time parameters. Bit positions are derived from them as follows. The bit index is (bank offset + pin − bank first pin) × stride, where the stride is 2 for drive strength and 1 for every other class. The word address is the class base + index / 32. The bit within that word is the index modulo 32.

Top module: `gpio_cfg_top`

## Requirements
- R1: After a synchronous reset, every pin is an input (padOe = 0). Output level, pull enable, pull-up and drive code are all 0. The direction word reads 1 in every assigned bit.
- R2: A pin's setting sits in word (class base + idx/32) at bit (idx mod 32), where idx = (bank offset + pin − bank first) × stride. With the default parameters, the classes sit at these byte addresses: direction 0x00, output 0x04, input 0x08, pull enable 0x0C, pull-up 0x10, and drive strength 0x14–0x18. Read data appears on rdata in the cycle after rdEn is sampled.
- R3: A direction bit of 1 makes the pin an input (padOe low). A direction bit of 0 makes it an output (padOe high).
- R4: padOut follows the stored output bit whatever the direction. The level can therefore be set while the pin is still an input and is already correct when output mode is turned on.
- R5: pullEn follows the pull-enable bit. pullUp follows the pull-polarity bit: 1 selects pull-up, 0 selects pull-down. Neither has any effect while pull enable is 0.
- R6: Drive strength is a 2-bit code per pin, placed at twice the pin's position, and it may cross a word boundary. Code 0 means 500 µA, 1 means 2500 µA, 2 means 3000 µA and 3 means 4000 µA. The code appears on drvCode[2p+1:2p].
- R7: A write updates only bits in byte lanes whose byteEn bit is set (lane k covers wdata[8k+7:8k]). All other stored bits keep their values.
- R8: Bits not assigned to any bank read as 0 and ignore writes. Pins outside every bank never leave their reset values.
- R9: The input class is read-only. It shows padIn after a two-flop synchronizer: a read sampled one clock after padIn changes still returns the old level. Writes to the input word change nothing.
- R10: Any access whose address is outside the mapped words, or whose two low address bits are nonzero, changes no state. It sets accErr high for exactly the cycle after the access, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe; takes priority over rdEn |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| byteEn | input | 4 | Write byte-lane enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| accErr | output | 1 | One-cycle pulse after an unmapped or misaligned access |
| padIn | input | NUM_PINS | Live pad input levels |
| padOe | output | NUM_PINS | Per-pin output enable |
| padOut | output | NUM_PINS | Per-pin output level |
| pullEn | output | NUM_PINS | Per-pin pull enable |
| pullUp | output | NUM_PINS | Per-pin pull polarity, 1 = up |
| drvCode | output | 2*NUM_PINS | Per-pin drive-strength code |

## Verification
The bench uses the default parameters: 24 pins in two banks (pins 0–9 and 12–21), with pins 10, 11, 22 and 23 left unassigned. The second bank starts at bit 16 in most classes, at bit 20 in pull enable and at pair 10 in drive strength. These values bring several cases within reach. Two banks share each word. The unassigned bit ranges differ from class to class. The second bank's drive codes run from the end of one word into the next. Gap pins must stay at their reset values even when every word is written with all ones.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  // width of one entry in the packed parameter tables
  localparam int FIELD_W     = 8;
  localparam int WORD_W      = 30;
  localparam int NUM_CLASSES = 6;

  // register classes; index into the per-class parameter tables
  localparam int CLS_DIR = 0;
  localparam int CLS_OUT = 1;
  localparam int CLS_IN  = 2;
  localparam int CLS_PEN = 3;
  localparam int CLS_PUP = 4;
  localparam int CLS_DRV = 5;

  typedef struct packed {
    logic              wr;      // write to a mapped word
    logic              rd;      // read of a mapped word
    logic              rdMiss;  // read of an unmapped word
    logic [WORD_W-1:0] word;    // word index of the access
  } cfg_strobe_t;

  function automatic int classStride(int cls);
    return (cls == CLS_DRV) ? 2 : 1;
  endfunction
endpackage

// File: rtl/gpio_cfg_field.sv
module gpio_cfg_field
  import gpio_cfg_pkg::*;
#(
  parameter int WORD    = 0,
  parameter int BITPOS  = 0,
  parameter int WIDTH   = 1,
  parameter bit RST_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  input  logic              laneEn,
  input  logic [WIDTH-1:0]  wbits,
  output logic [WIDTH-1:0]  q,
  output logic [31:0]       rdPart
);
  logic sel;
  assign sel = (word == WORD_W'(WORD));

  always_ff @(posedge clk) begin
    if (rst)                      q <= WIDTH'(RST_ONE);
    else if (wr && sel && laneEn) q <= wbits;
  end

  always_comb begin
    rdPart = '0;
    if (sel) rdPart[BITPOS +: WIDTH] = q;
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst) !wr |=> $stable(q)); // R10
endmodule

// File: rtl/gpio_cfg_ctrl.sv
module gpio_cfg_ctrl
  import gpio_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [NUM_CLASSES*FIELD_W-1:0] CLASS_BASE  = '0,
  parameter logic [NUM_CLASSES*FIELD_W-1:0] CLASS_WORDS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output cfg_strobe_t       strobe,
  output logic              accErr
);
  logic hit;
  logic aligned;

  always_comb begin
    int w;
    w       = int'(addr[ADDR_W-1:2]);
    aligned = (addr[1:0] == 2'b00);
    hit     = 1'b0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (w >= int'(CLASS_BASE[c*FIELD_W +: FIELD_W]) &&
          w <  int'(CLASS_BASE[c*FIELD_W +: FIELD_W]) + int'(CLASS_WORDS[c*FIELD_W +: FIELD_W]))
        hit = aligned;
    end
  end

  // write wins when both strobes are raised together
  always_comb begin
    strobe.wr     = wrEn && hit;
    strobe.rd     = rdEn && !wrEn && hit;
    strobe.rdMiss = rdEn && !wrEn && !hit;
    strobe.word   = WORD_W'(addr[ADDR_W-1:2]);
  end

  always_ff @(posedge clk) begin
    if (rst) accErr <= 1'b0;
    else     accErr <= (wrEn || rdEn) && !hit;
  end

  AST_ERR_CAUSE:   assert property (@(posedge clk) disable iff (rst) accErr |-> $past(wrEn || rdEn)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({strobe.wr, strobe.rd, strobe.rdMiss})); // R10
endmodule

// File: rtl/gpio_cfg_dp.sv
module gpio_cfg_dp
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*FIELD_W-1:0]             BANK_FIRST = '0,
  parameter logic [NUM_BANKS*FIELD_W-1:0]             BANK_LAST  = '0,
  parameter logic [NUM_BANKS*NUM_CLASSES*FIELD_W-1:0] BANK_OFF   = '0,
  parameter logic [NUM_CLASSES*FIELD_W-1:0]           CLASS_BASE = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  cfg_strobe_t           strobe,
  input  logic [3:0]            byteEn,
  input  logic [31:0]           wdata,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [31:0]           rdata,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   pullEn,
  output logic [NUM_PINS-1:0]   pullUp,
  output logic [2*NUM_PINS-1:0] drvCode
);
  localparam int NUM_PARTS = NUM_PINS * NUM_CLASSES;

  function automatic int findBank(int pin);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (pin >= int'(BANK_FIRST[b*FIELD_W +: FIELD_W]) && pin <= int'(BANK_LAST[b*FIELD_W +: FIELD_W]))
        return b;
    end
    return -1;
  endfunction

  function automatic int bitIndex(int pin, int bank, int cls);
    return (int'(BANK_OFF[(bank*NUM_CLASSES+cls)*FIELD_W +: FIELD_W]) + pin
            - int'(BANK_FIRST[bank*FIELD_W +: FIELD_W])) * classStride(cls);
  endfunction

  function automatic int wordOf(int pin, int bank, int cls);
    return int'(CLASS_BASE[cls*FIELD_W +: FIELD_W]) + bitIndex(pin, bank, cls) / 32;
  endfunction

  function automatic int bitOf(int pin, int bank, int cls);
    return bitIndex(pin, bank, cls) % 32;
  endfunction

  logic [NUM_PINS-1:0] syncA, syncB;
  logic [31:0]         parts [NUM_PARTS];
  logic [31:0]         rdAcc;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    localparam int BK = findBank(p);
    if (BK >= 0) begin : gMap
      localparam int W_DIR = wordOf(p, BK, CLS_DIR), B_DIR = bitOf(p, BK, CLS_DIR);
      localparam int W_OUT = wordOf(p, BK, CLS_OUT), B_OUT = bitOf(p, BK, CLS_OUT);
      localparam int W_IN  = wordOf(p, BK, CLS_IN),  B_IN  = bitOf(p, BK, CLS_IN);
      localparam int W_PEN = wordOf(p, BK, CLS_PEN), B_PEN = bitOf(p, BK, CLS_PEN);
      localparam int W_PUP = wordOf(p, BK, CLS_PUP), B_PUP = bitOf(p, BK, CLS_PUP);
      localparam int W_DRV = wordOf(p, BK, CLS_DRV), B_DRV = bitOf(p, BK, CLS_DRV);
      logic dirQ, outQ, penQ, pupQ;
      logic [1:0] drvQ;

      gpio_cfg_field #(.WORD(W_DIR), .BITPOS(B_DIR), .WIDTH(1), .RST_ONE(1'b1)) uDir (
        .clk, .rst, .wr(strobe.wr), .word(strobe.word), .laneEn(byteEn[B_DIR/8]),
        .wbits(wdata[B_DIR]), .q(dirQ), .rdPart(parts[p*NUM_CLASSES+CLS_DIR]));
      gpio_cfg_field #(.WORD(W_OUT), .BITPOS(B_OUT), .WIDTH(1), .RST_ONE(1'b0)) uOut (
        .clk, .rst, .wr(strobe.wr), .word(strobe.word), .laneEn(byteEn[B_OUT/8]),
        .wbits(wdata[B_OUT]), .q(outQ), .rdPart(parts[p*NUM_CLASSES+CLS_OUT]));
      gpio_cfg_field #(.WORD(W_PEN), .BITPOS(B_PEN), .WIDTH(1), .RST_ONE(1'b0)) uPen (
        .clk, .rst, .wr(strobe.wr), .word(strobe.word), .laneEn(byteEn[B_PEN/8]),
        .wbits(wdata[B_PEN]), .q(penQ), .rdPart(parts[p*NUM_CLASSES+CLS_PEN]));
      gpio_cfg_field #(.WORD(W_PUP), .BITPOS(B_PUP), .WIDTH(1), .RST_ONE(1'b0)) uPup (
        .clk, .rst, .wr(strobe.wr), .word(strobe.word), .laneEn(byteEn[B_PUP/8]),
        .wbits(wdata[B_PUP]), .q(pupQ), .rdPart(parts[p*NUM_CLASSES+CLS_PUP]));
      gpio_cfg_field #(.WORD(W_DRV), .BITPOS(B_DRV), .WIDTH(2), .RST_ONE(1'b0)) uDrv (
        .clk, .rst, .wr(strobe.wr), .word(strobe.word), .laneEn(byteEn[B_DRV/8]),
        .wbits(wdata[B_DRV +: 2]), .q(drvQ), .rdPart(parts[p*NUM_CLASSES+CLS_DRV]));

      // input class: read-only view of the synchronized pad level
      assign parts[p*NUM_CLASSES+CLS_IN] =
        (strobe.word == WORD_W'(W_IN)) ? (32'(syncB[p]) << B_IN) : '0;

      assign padOe[p]         = ~dirQ;
      assign padOut[p]        = outQ;
      assign pullEn[p]        = penQ;
      assign pullUp[p]        = pupQ;
      assign drvCode[2*p +: 2] = drvQ;
    end else begin : gGap
      for (genvar c = 0; c < NUM_CLASSES; c++) begin : gZero
        assign parts[p*NUM_CLASSES+c] = '0;
      end
      assign padOe[p]          = 1'b0;
      assign padOut[p]         = 1'b0;
      assign pullEn[p]         = 1'b0;
      assign pullUp[p]         = 1'b0;
      assign drvCode[2*p +: 2] = 2'b00;
    end
  end

  always_comb begin
    rdAcc = '0;
    for (int i = 0; i < NUM_PARTS; i++) rdAcc |= parts[i];
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (strobe.rd)     rdata <= rdAcc;
    else if (strobe.rdMiss) rdata <= '0;
  end

  AST_RESET_INPUT: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (padOe == '0)); // R1
  AST_MISS_ZERO:   assert property (@(posedge clk) disable iff (rst) strobe.rdMiss |=> (rdata == '0)); // R10
endmodule

// File: rtl/gpio_cfg_top.sv
module gpio_cfg_top
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  parameter logic [NUM_BANKS*FIELD_W-1:0] BANK_FIRST = {8'd12, 8'd0},
  parameter logic [NUM_BANKS*FIELD_W-1:0] BANK_LAST  = {8'd21, 8'd9},
  // per bank, classes drive..direction from left to right
  parameter logic [NUM_BANKS*NUM_CLASSES*FIELD_W-1:0] BANK_OFF =
    {8'd10, 8'd16, 8'd20, 8'd16, 8'd16, 8'd16,
     8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0},
  parameter logic [NUM_CLASSES*FIELD_W-1:0] CLASS_BASE  = {8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0},
  parameter logic [NUM_CLASSES*FIELD_W-1:0] CLASS_WORDS = {8'd2, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [3:0]            byteEn,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic                  accErr,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   pullEn,
  output logic [NUM_PINS-1:0]   pullUp,
  output logic [2*NUM_PINS-1:0] drvCode
);
  cfg_strobe_t strobe;

  gpio_cfg_ctrl #(
    .ADDR_W(ADDR_W), .CLASS_BASE(CLASS_BASE), .CLASS_WORDS(CLASS_WORDS)
  ) i_ctrl (
    .clk, .rst, .wrEn, .rdEn, .addr, .strobe, .accErr
  );

  gpio_cfg_dp #(
    .NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS), .BANK_FIRST(BANK_FIRST),
    .BANK_LAST(BANK_LAST), .BANK_OFF(BANK_OFF), .CLASS_BASE(CLASS_BASE)
  ) i_dp (
    .clk, .rst, .strobe, .byteEn, .wdata, .padIn, .rdata,
    .padOe, .padOut, .pullEn, .pullUp, .drvCode
  );
endmodule

// File: tb/test_gpio_cfg_top.sv
module test_gpio_cfg_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP         = 24;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]    addr = '0;
  logic [3:0]    byteEn = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          accErr;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOe, padOut, pullEn, pullUp;
  logic [2*NP-1:0] drvCode;

  int checks = 0;
  int errors = 0;

  logic [31:0] qData[$];
  logic        qErr[$];
  string       qTag[$];
  logic        rdSeen = 1'b0;
  logic [31:0] expD;
  logic        expE;
  string       expT;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_cfg_top i_gpio_cfg_top (
    .clk, .rst, .wrEn, .rdEn, .addr, .byteEn, .wdata, .rdata, .accErr,
    .padIn, .padOe, .padOut, .pullEn, .pullUp, .drvCode
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; byteEn = be; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; byteEn = '0;
  endtask

  // driver: pushes the expected read result, the monitor compares it
  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input logic expErr, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    qData.push_back(exp); qErr.push_back(expErr); qTag.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  always @(posedge clk) rdSeen <= rdEn && !wrEn && !rst;

  // monitor
  always @(negedge clk) begin
    if (rdSeen) begin
      if (qData.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor: read result with no expected item, actual=%0h expected=none", rdata);
      end else begin
        expD = qData.pop_front();
        expE = qErr.pop_front();
        expT = qTag.pop_front();
        check({expT, " data"}, 64'(rdata), 64'(expD));
        check({expT, " err"},  64'(accErr), 64'(expE));
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 padOe",   64'(padOe),   64'h0);
    check("R1 padOut",  64'(padOut),  64'h0);
    check("R1 pullEn",  64'(pullEn),  64'h0);
    check("R1 pullUp",  64'(pullUp),  64'h0);
    check("R1 drvCode", 64'(drvCode), 64'h0);
    check("R1 accErr",  64'(accErr),  64'h0);
    busRead(8'h00, 32'h03FF03FF, 1'b0, "R1 R2 dir reset");
    busRead(8'h04, 32'h0, 1'b0, "R1 out reset");
    busRead(8'h0C, 32'h0, 1'b0, "R1 pen reset");
    busRead(8'h14, 32'h0, 1'b0, "R1 drv lo reset");
    busRead(8'h18, 32'h0, 1'b0, "R1 drv hi reset");

    // R8 unassigned bits and gap pins
    busWrite(8'h00, 4'hF, 32'hFFFFFFFF);
    busRead(8'h00, 32'h03FF03FF, 1'b0, "R8 dir all ones");
    busWrite(8'h04, 4'hF, 32'hFFFFFFFF);
    busRead(8'h04, 32'h03FF03FF, 1'b0, "R8 out all ones");
    check("R8 padOut gap pins", 64'(padOut), 64'h3FF3FF);
    busWrite(8'h04, 4'hF, 32'h0);

    // R4 level set while input
    busWrite(8'h04, 4'hF, 32'h00010001);
    check("R4 padOut while input", 64'(padOut), 64'h001001);
    check("R4 padOe still off",    64'(padOe),  64'h0);
    // R3 direction inverted
    busWrite(8'h00, 4'hF, 32'hFFFEFFFE);
    check("R3 padOe pins 0 and 12", 64'(padOe),  64'h001001);
    check("R4 padOut kept",         64'(padOut), 64'h001001);
    busRead(8'h00, 32'h03FE03FE, 1'b0, "R3 dir readback");
    busWrite(8'h00, 4'hF, 32'hFFFDFFFF);
    check("R2 R3 pin13 at bit17", 64'(padOe), 64'h002000);

    // R5 pulls, bank 1 at offset 20 in pull enable
    busWrite(8'h0C, 4'hF, 32'h20100008);
    check("R5 pullEn", 64'(pullEn), 64'h201008);
    check("R5 pullUp before", 64'(pullUp), 64'h0);
    busWrite(8'h10, 4'hF, 32'h00000008);
    check("R5 pullUp pin3", 64'(pullUp), 64'h000008);
    busRead(8'h0C, 32'h20100008, 1'b0, "R5 pen readback");
    busWrite(8'h0C, 4'hF, 32'hFFFFFFFF);
    busRead(8'h0C, 32'h3FF003FF, 1'b0, "R8 R2 pen assigned bits");
    check("R5 pullEn all", 64'(pullEn), 64'h3FF3FF);
    busWrite(8'h0C, 4'hF, 32'h0);

    // R6 drive codes spanning two words
    busWrite(8'h18, 4'hF, 32'h000000E4);
    check("R6 drv upper word", 64'(drvCode), 64'h0E4000000000);
    busRead(8'h18, 32'h000000E4, 1'b0, "R6 drv hi readback");
    busWrite(8'h14, 4'hF, 32'hC0000003);
    check("R6 drv lower word", 64'(drvCode), 64'h0E4C00000003);
    busRead(8'h14, 32'hC0000003, 1'b0, "R6 drv lo readback");

    // R7 byte lanes
    busWrite(8'h14, 4'b0001, 32'hFFFFFFFF);
    busRead(8'h14, 32'hC00000FF, 1'b0, "R7 lane0 only");
    check("R7 drv lane0", 64'(drvCode), 64'h0E4C000000FF);
    busWrite(8'h00, 4'b0100, 32'h0);
    check("R7 dir lane2", 64'(padOe), 64'h0FF000);
    busRead(8'h00, 32'h030003FF, 1'b0, "R7 dir readback");

    // R9 synchronized read-only input
    @(negedge clk);
    padIn = 24'hABCDEF;
    busRead(8'h08, 32'h0, 1'b0, "R9 sync lag");
    repeat (2) @(negedge clk);
    busRead(8'h08, 32'h02BC01EF, 1'b0, "R9 input value");
    busWrite(8'h08, 4'hF, 32'h0);
    busRead(8'h08, 32'h02BC01EF, 1'b0, "R9 read-only");

    // R10 unmapped and misaligned
    busRead(8'h1C, 32'h0, 1'b1, "R10 unmapped read");
    busWrite(8'h1C, 4'hF, 32'hFFFFFFFF);
    check("R10 err after write", 64'(accErr), 64'h1);
    @(negedge clk);
    check("R10 err one cycle", 64'(accErr), 64'h0);
    check("R10 drv unchanged", 64'(drvCode), 64'h0E4C000000FF);
    busRead(8'h00, 32'h030003FF, 1'b0, "R10 dir unchanged");
    busWrite(8'h01, 4'hF, 32'h0);
    check("R10 misaligned write err", 64'(accErr), 64'h1);
    check("R10 misaligned no change", 64'(padOe), 64'h0FF000);
    busRead(8'h01, 32'h0, 1'b1, "R10 misaligned read");
    busRead(8'hFC, 32'h0, 1'b1, "R10 far read");

    while (qData.size() != 0) @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule